// File: doc/BRIEF.md
# Array Write-Protect Command Controller

This block sits beside the byte-level engine of a two-wire serial memory slave and decides, for each received byte, whether the slave acknowledges it. It also decides whether each data byte of a write frame may start a write into a 256-byte array. The bus engine reports Start and Stop events and each completed byte. The controller returns a registered acknowledge decision one cycle later. For data bytes, it also returns a registered write strobe with the target address and data.

Two software protect flags guard the lower half of the array (00h to 7Fh). One flag can be set and cleared. The other, once set, can never be cleared. A hardware protect input guards every address. Protect commands arrive as three-byte write-style frames. They use the device-type nibble 0110 instead of the memory nibble 1010. They are accepted only when the high-voltage qualifier is asserted and two select pins carry the command code. The flags model nonvolatile cells. The initial reset clears them, as for blank cells. A modelled power cycle keeps them and clears only the frame and pointer state.

Top module: `array_wp_ctrl`

## Requirements
- R1: After `rst`, `ack_vld` and `wr_en` are low, both software flags are clear, and a write to address 05h is enabled.
- R2: Every `byte_vld` pulse gives exactly one `ack_vld` pulse in the following cycle, with `ack_o` showing the decision. In a write frame with control nibble 1010 and bit 0 = 0, the control, address and data bytes are all acknowledged.
- R3: In a write frame, the second byte loads the address pointer. Each later byte raises `wr_en` with `wr_addr` = pointer and `wr_data` = byte. The pointer then increments only in its low 4 bits, so it wraps within a 16-byte page (1Fh is followed by 10h).
- R4: While `hw_wp` is 1, no address 00h–FFh is written, but data bytes are still acknowledged.
- R5: While either software flag is set, addresses 00h–7Fh are not written and addresses 80h–FFh are written normally. Data bytes are acknowledged in both cases.
- R6: A control byte with nibble 0110 and bit 0 = 0 is acknowledged only when `hv_a0` = 1, the permanent flag is clear, and {`sel_a2`,`sel_a1`} is 00, 01 or 11. The following bytes of that frame are acknowledged. Otherwise the control byte and the rest of its frame are not acknowledged.
- R7: A Stop that ends an acknowledged command frame of exactly three bytes executes it: code 00 sets the resettable flag, code 01 clears it. The address and data byte values do not matter.
- R8: A command frame with two bytes, with four bytes, or cut off by a repeated Start changes no flag.
- R9: Code 11 sets the permanent flag. After that, 00h–7Fh stay unwritable through any later command, `pwr_cycle` pulse or `hw_wp` toggle, while 80h–FFh stay writable.
- R10: Once the permanent flag is set, any 0110 control byte is not acknowledged.
- R11: A `pwr_cycle` pulse keeps both flags.
- R12: In a read frame (nibble 1010, bit 0 = 1), only the control byte is acknowledged. A frame with any other nibble, and a byte received outside a frame, get no acknowledge and cause no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high initial reset; clears the flags |
| pwr_cycle | input | 1 | Modelled power cycle; clears frame state, keeps the flags |
| bus_start | input | 1 | Start or repeated Start seen on the bus (pulse) |
| bus_stop | input | 1 | Stop seen on the bus (pulse) |
| byte_vld | input | 1 | A byte has been received (pulse) |
| byte_dat | input | 8 | Received byte |
| hv_a0 | input | 1 | High-voltage qualifier from pin A0 |
| sel_a1 | input | 1 | Command select level, low bit |
| sel_a2 | input | 1 | Command select level, high bit |
| hw_wp | input | 1 | Hardware protect for the whole array |
| ack_vld | output | 1 | Acknowledge decision valid (one cycle per byte) |
| ack_o | output | 1 | 1 = acknowledge the byte |
| wr_en | output | 1 | Start an array write |
| wr_addr | output | ADDR_W | Array write address |
| wr_data | output | 8 | Array write data |

## Verification
The hardest state to reach is the permanent lock. It must be shown to survive attempts to undo it. Once set, it cannot be cleared again within a run, so the vector table sets it last. Every earlier check runs with the lock still open. After the lock, the table tries a clear command, a power cycle and a hardware-protect toggle. It then probes address 05h through a normal write frame. The aborted command frames (short, long, and cut by a repeated Start) are each followed at once by a probe write to the lower half. This shows at the ports that the flag did not move.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] MEM_ID  = 4'b1010;
  localparam logic [3:0] PROT_ID = 4'b0110;

  typedef enum logic [2:0] {
    FR_IDLE, FR_OPEN, FR_WRITE, FR_READ, FR_CMD, FR_SKIP
  } frame_e;

  typedef enum logic [1:0] {
    CMD_SET  = 2'b00,
    CMD_CLR  = 2'b01,
    CMD_RSV  = 2'b10,
    CMD_LOCK = 2'b11
  } cmd_e;
endpackage

// File: rtl/wp_frame_dec.sv
module wp_frame_dec
  import wp_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_cycle,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       byte_vld,
  input  logic [3:0] id_nib,
  input  logic       rw_bit,
  input  logic       hv_ok,
  input  logic [1:0] sel,
  input  logic       perm_i,
  output logic       byte_ack,
  output logic       is_addr,
  output logic       is_data,
  output logic       cmd_go,
  output cmd_e       cmd_code
);
  localparam logic [CNT_W-1:0] CMD_LEN = CNT_W'(3);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  frame_e           kind_q, kind_nx;
  logic [CNT_W-1:0] cnt_q;
  cmd_e             code_q;
  logic             cmd_ok, ack_raw;

  always_comb begin
    cmd_ok  = (id_nib == PROT_ID) && !rw_bit && hv_ok && !perm_i && (sel != CMD_RSV);
    kind_nx = FR_SKIP;
    if (id_nib == MEM_ID) kind_nx = rw_bit ? FR_READ : FR_WRITE;
    else if (cmd_ok)      kind_nx = FR_CMD;
    case (kind_q)
      FR_OPEN:          ack_raw = (kind_nx != FR_SKIP);
      FR_WRITE, FR_CMD: ack_raw = 1'b1;
      default:          ack_raw = 1'b0;
    endcase
  end

  assign byte_ack = byte_vld && ack_raw;
  assign is_addr  = byte_vld && (kind_q == FR_WRITE) && (cnt_q == CNT_W'(1));
  assign is_data  = byte_vld && (kind_q == FR_WRITE) && (cnt_q >= CNT_W'(2));
  assign cmd_go   = bus_stop && !bus_start && (kind_q == FR_CMD) && (cnt_q == CMD_LEN);
  assign cmd_code = code_q;

  always_ff @(posedge clk) begin
    if (rst || pwr_cycle) begin
      kind_q <= FR_IDLE;
      cnt_q  <= '0;
      code_q <= CMD_SET;
    end else if (bus_start) begin
      kind_q <= FR_OPEN;
      cnt_q  <= '0;
    end else if (bus_stop) begin
      kind_q <= FR_IDLE;
    end else if (byte_vld && kind_q != FR_IDLE) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (kind_q == FR_OPEN) begin
        kind_q <= kind_nx;
        code_q <= cmd_e'(sel);
      end
    end
  end

  // R10
  no_cmd_after_lock_chk: assert property (@(posedge clk) disable iff (rst)
    perm_i |-> kind_q != FR_CMD);
  // R12
  read_never_writes_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_q == FR_READ) |-> !is_data && !byte_ack);
endmodule

// File: rtl/wp_flags.sv
module wp_flags
  import wp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_go,
  input  cmd_e cmd_code,
  output logic soft_q,
  output logic perm_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      soft_q <= 1'b0;
      perm_q <= 1'b0;
    end else if (cmd_go) begin
      case (cmd_code)
        CMD_SET:  soft_q <= 1'b1;
        CMD_CLR:  soft_q <= 1'b0;
        CMD_LOCK: perm_q <= 1'b1;
        default:  ;
      endcase
    end
  end

  // R9
  perm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    perm_q |=> perm_q);
  // R8
  flags_only_on_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_go |=> $stable(soft_q) && $stable(perm_q));
endmodule

// File: rtl/wp_gate.sv
module wp_gate
  import wp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_cycle,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_dat,
  input  logic              byte_ack,
  input  logic              is_addr,
  input  logic              is_data,
  input  logic              hw_wp,
  input  logic              soft_i,
  input  logic              perm_i,
  output logic              ack_vld,
  output logic              ack_o,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int TOP = ADDR_W - 1;

  logic [ADDR_W-1:0] ptr_q;
  logic              blocked;

  assign blocked = hw_wp || ((soft_i || perm_i) && !ptr_q[TOP]);

  always_ff @(posedge clk) begin
    if (rst || pwr_cycle) begin
      ack_vld <= 1'b0;
      ack_o   <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      ptr_q   <= '0;
    end else begin
      ack_vld <= byte_vld;
      ack_o   <= byte_ack;
      wr_en   <= is_data && !blocked;
      if (is_addr) ptr_q <= byte_dat[ADDR_W-1:0];
      if (is_data) begin
        wr_addr <= ptr_q;
        wr_data <= byte_dat;
        ptr_q   <= {ptr_q[TOP:PAGE_BITS], ptr_q[PAGE_BITS-1:0] + 1'b1};
      end
    end
  end

  // R4
  hw_blocks_all_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(hw_wp));
  // R5
  low_half_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr[TOP]) |-> !$past(soft_i || perm_i));
  // R2
  write_is_acked_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ack_vld && ack_o);
endmodule

// File: rtl/array_wp_ctrl.sv
module array_wp_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_cycle,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              byte_vld,
  input  logic [7:0]        byte_dat,
  input  logic              hv_a0,
  input  logic              sel_a1,
  input  logic              sel_a2,
  input  logic              hw_wp,
  output logic              ack_vld,
  output logic              ack_o,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  logic byte_ack, is_addr, is_data, cmd_go, soft_q, perm_q;
  cmd_e cmd_code;

  wp_frame_dec #(.CNT_W(3)) dec_i (
    .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle),
    .bus_start(bus_start), .bus_stop(bus_stop), .byte_vld(byte_vld),
    .id_nib(byte_dat[7:4]), .rw_bit(byte_dat[0]),
    .hv_ok(hv_a0), .sel({sel_a2, sel_a1}), .perm_i(perm_q),
    .byte_ack(byte_ack), .is_addr(is_addr), .is_data(is_data),
    .cmd_go(cmd_go), .cmd_code(cmd_code)
  );

  wp_flags flags_i (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_code(cmd_code),
    .soft_q(soft_q), .perm_q(perm_q)
  );

  wp_gate #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) gate_i (
    .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .byte_ack(byte_ack),
    .is_addr(is_addr), .is_data(is_data), .hw_wp(hw_wp),
    .soft_i(soft_q), .perm_i(perm_q),
    .ack_vld(ack_vld), .ack_o(ack_o), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: tb/array_wp_ctrl_tb_top.sv
module array_wp_ctrl_tb_top;
  localparam logic [3:0] ST = 4'd0, BY = 4'd1, SP = 4'd2, PW = 4'd3,
                         HN = 4'd4, HF = 4'd5, WR = 4'd6, CM = 4'd7;
  localparam logic [2:0] P0 = 3'b000, PS = 3'b100, PC = 3'b101,
                         PL = 3'b111, PR = 3'b110;

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] ctl;
    logic [7:0] adr;
    logic [7:0] dat;
    logic [2:0] pins;
    logic [2:0] n;
    logic       ea;
    logic       ew;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 64;
  localparam vec_t VEC [NV] = '{
    '{ST, 8'h00, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd2},  // R2 raw write frame
    '{BY, 8'hA0, 8'h00, 8'h00, P0, 3'd0, 1'b1, 1'b0, 4'd2},
    '{BY, 8'h10, 8'h00, 8'h00, P0, 3'd0, 1'b1, 1'b0, 4'd2},
    '{BY, 8'h55, 8'h10, 8'h55, P0, 3'd0, 1'b1, 1'b1, 4'd3},  // R3
    '{BY, 8'h66, 8'h11, 8'h66, P0, 3'd0, 1'b1, 1'b1, 4'd3},
    '{SP, 8'h00, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd2},
    '{ST, 8'h00, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd3},  // R3 page wrap
    '{BY, 8'hA0, 8'h00, 8'h00, P0, 3'd0, 1'b1, 1'b0, 4'd3},
    '{BY, 8'h1E, 8'h00, 8'h00, P0, 3'd0, 1'b1, 1'b0, 4'd3},
    '{BY, 8'h11, 8'h1E, 8'h11, P0, 3'd0, 1'b1, 1'b1, 4'd3},
    '{BY, 8'h22, 8'h1F, 8'h22, P0, 3'd0, 1'b1, 1'b1, 4'd3},
    '{BY, 8'h33, 8'h10, 8'h33, P0, 3'd0, 1'b1, 1'b1, 4'd3},
    '{SP, 8'h00, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd3},
    '{CM, 8'h60, 8'h00, 8'h00, PS, 3'd2, 1'b1, 1'b0, 4'd7},  // R7 set soft
    '{WR, 8'h00, 8'h05, 8'h77, P0, 3'd0, 1'b1, 1'b0, 4'd5},  // R5
    '{WR, 8'h00, 8'h85, 8'h78, P0, 3'd0, 1'b1, 1'b1, 4'd5},
    '{WR, 8'h00, 8'h7F, 8'h11, P0, 3'd0, 1'b1, 1'b0, 4'd5},
    '{WR, 8'h00, 8'h80, 8'h12, P0, 3'd0, 1'b1, 1'b1, 4'd5},
    '{CM, 8'h60, 8'h00, 8'h00, P0, 3'd2, 1'b0, 1'b0, 4'd6},  // R6 no qualifier
    '{CM, 8'h60, 8'h00, 8'h00, PR, 3'd2, 1'b0, 1'b0, 4'd6},  // R6 reserved code
    '{CM, 8'h61, 8'h00, 8'h00, PC, 3'd2, 1'b0, 1'b0, 4'd6},  // R6 read bit
    '{CM, 8'h60, 8'h00, 8'h00, PC, 3'd1, 1'b1, 1'b0, 4'd8},  // R8 short
    '{WR, 8'h00, 8'h05, 8'h79, P0, 3'd0, 1'b1, 1'b0, 4'd8},
    '{CM, 8'h60, 8'h00, 8'h00, PC, 3'd3, 1'b1, 1'b0, 4'd8},  // R8 long
    '{WR, 8'h00, 8'h05, 8'h79, P0, 3'd0, 1'b1, 1'b0, 4'd8},
    '{ST, 8'h00, 8'h00, 8'h00, PC, 3'd0, 1'b0, 1'b0, 4'd8},  // R8 repeated start
    '{BY, 8'h60, 8'h00, 8'h00, PC, 3'd0, 1'b1, 1'b0, 4'd8},
    '{BY, 8'h00, 8'h00, 8'h00, PC, 3'd0, 1'b1, 1'b0, 4'd8},
    '{ST, 8'h00, 8'h00, 8'h00, PC, 3'd0, 1'b0, 1'b0, 4'd8},
    '{BY, 8'hA0, 8'h00, 8'h00, PC, 3'd0, 1'b1, 1'b0, 4'd8},
    '{BY, 8'h06, 8'h00, 8'h00, PC, 3'd0, 1'b1, 1'b0, 4'd8},
    '{BY, 8'h7A, 8'h06, 8'h7A, PC, 3'd0, 1'b1, 1'b0, 4'd8},
    '{SP, 8'h00, 8'h00, 8'h00, PC, 3'd0, 1'b0, 1'b0, 4'd8},
    '{CM, 8'h60, 8'hC3, 8'h5A, PC, 3'd2, 1'b1, 1'b0, 4'd7},  // R7 clear
    '{WR, 8'h00, 8'h05, 8'h7B, P0, 3'd0, 1'b1, 1'b1, 4'd7},
    '{CM, 8'h60, 8'h00, 8'h00, PS, 3'd2, 1'b1, 1'b0, 4'd11}, // R11
    '{PW, 8'h00, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd11},
    '{WR, 8'h00, 8'h05, 8'h7C, P0, 3'd0, 1'b1, 1'b0, 4'd11},
    '{CM, 8'h60, 8'h00, 8'h00, PC, 3'd2, 1'b1, 1'b0, 4'd7},
    '{WR, 8'h00, 8'h05, 8'h7D, P0, 3'd0, 1'b1, 1'b1, 4'd7},
    '{HN, 8'h00, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd4},  // R4
    '{WR, 8'h00, 8'h85, 8'h21, P0, 3'd0, 1'b1, 1'b0, 4'd4},
    '{WR, 8'h00, 8'h05, 8'h22, P0, 3'd0, 1'b1, 1'b0, 4'd4},
    '{HF, 8'h00, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd4},
    '{WR, 8'h00, 8'h85, 8'h23, P0, 3'd0, 1'b1, 1'b1, 4'd4},
    '{ST, 8'h00, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd12}, // R12 read
    '{BY, 8'hA1, 8'h00, 8'h00, P0, 3'd0, 1'b1, 1'b0, 4'd12},
    '{BY, 8'h3C, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd12},
    '{SP, 8'h00, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd12},
    '{ST, 8'h00, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd12}, // R12 foreign id
    '{BY, 8'h50, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd12},
    '{BY, 8'h00, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd12},
    '{SP, 8'h00, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd12},
    '{BY, 8'hA0, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd12}, // R12 outside frame
    '{CM, 8'h60, 8'h00, 8'h00, PL, 3'd2, 1'b1, 1'b0, 4'd9},  // R9 lock
    '{WR, 8'h00, 8'h05, 8'h31, P0, 3'd0, 1'b1, 1'b0, 4'd9},
    '{WR, 8'h00, 8'h90, 8'h32, P0, 3'd0, 1'b1, 1'b1, 4'd9},
    '{CM, 8'h60, 8'h00, 8'h00, PC, 3'd2, 1'b0, 1'b0, 4'd10}, // R10
    '{WR, 8'h00, 8'h05, 8'h33, P0, 3'd0, 1'b1, 1'b0, 4'd9},
    '{PW, 8'h00, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd9},
    '{HN, 8'h00, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd9},
    '{HF, 8'h00, 8'h00, 8'h00, P0, 3'd0, 1'b0, 1'b0, 4'd9},
    '{WR, 8'h00, 8'h05, 8'h34, P0, 3'd0, 1'b1, 1'b0, 4'd9},
    '{CM, 8'h60, 8'h00, 8'h00, PS, 3'd2, 1'b0, 1'b0, 4'd10}  // R10
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1, pwr_cycle = 1'b0, bus_start = 1'b0, bus_stop = 1'b0;
  logic       byte_vld = 1'b0, hv_a0 = 1'b0, sel_a1 = 1'b0, sel_a2 = 1'b0, hw_wp = 1'b0;
  logic [7:0] byte_dat = 8'h00;
  logic       ack_vld, ack_o, wr_en;
  logic [7:0] wr_addr, wr_data;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  array_wp_ctrl dut_i (
    .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle), .bus_start(bus_start),
    .bus_stop(bus_stop), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .hv_a0(hv_a0), .sel_a1(sel_a1), .sel_a2(sel_a2), .hw_wp(hw_wp),
    .ack_vld(ack_vld), .ack_o(ack_o), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse(input int which);
    case (which)
      0: bus_start = 1'b1;
      1: bus_stop  = 1'b1;
      default: pwr_cycle = 1'b1;
    endcase
    @(negedge clk);
    bus_start = 1'b0; bus_stop = 1'b0; pwr_cycle = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic [2:0] pins, input logic ea,
                      input logic ew, input logic [7:0] eadr, input int req);
    {hv_a0, sel_a2, sel_a1} = pins;
    byte_dat = b;
    byte_vld = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0;
    check(2, "ack_vld", 32'(ack_vld), 32'd1);
    check(req, "ack_o", 32'(ack_o), 32'(ea));
    check(req, "wr_en", 32'(wr_en), 32'(ew));
    if (ew) begin
      check(req, "wr_addr", 32'(wr_addr), 32'(eadr));
      check(req, "wr_data", 32'(wr_data), 32'(b));
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(1, "ack_vld after reset", 32'(ack_vld), 32'd0);
    check(1, "wr_en after reset", 32'(wr_en), 32'd0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        ST: pulse(0);
        SP: pulse(1);
        PW: pulse(2);
        HN: begin hw_wp = 1'b1; @(negedge clk); end
        HF: begin hw_wp = 1'b0; @(negedge clk); end
        BY: send(VEC[i].ctl, VEC[i].pins, VEC[i].ea, VEC[i].ew, VEC[i].adr, int'(VEC[i].req));
        WR: begin
          pulse(0);
          send(8'hA0, P0, 1'b1, 1'b0, 8'h00, int'(VEC[i].req));
          send(VEC[i].adr, P0, 1'b1, 1'b0, 8'h00, int'(VEC[i].req));
          send(VEC[i].dat, P0, VEC[i].ea, VEC[i].ew, VEC[i].adr, int'(VEC[i].req));
          pulse(1);
        end
        CM: begin
          pulse(0);
          send(VEC[i].ctl, VEC[i].pins, VEC[i].ea, 1'b0, 8'h00, int'(VEC[i].req));
          for (int k = 0; k < int'(VEC[i].n); k++)
            send(k == 0 ? VEC[i].adr : VEC[i].dat, VEC[i].pins, VEC[i].ea, 1'b0, 8'h00, int'(VEC[i].req));
          pulse(1);
        end
        default: @(negedge clk);
      endcase
    end

    // R2: acknowledge strobe lasts one cycle only
    pulse(0);
    send(8'hA0, P0, 1'b1, 1'b0, 8'h00, 2);
    @(negedge clk);
    check(2, "ack_vld single cycle", 32'(ack_vld), 32'd0);
    pulse(1);

    // R1: initial reset clears even the permanent lock
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(1, "ack_vld in reset", 32'(ack_vld), 32'd0);
    check(1, "wr_en in reset", 32'(wr_en), 32'd0);
    pulse(0);
    send(8'hA0, P0, 1'b1, 1'b0, 8'h00, 1);
    send(8'h05, P0, 1'b1, 1'b0, 8'h00, 1);
    send(8'hE7, P0, 1'b1, 1'b1, 8'h05, 1);
    pulse(1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule